// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter with Split Test Mode

This block keeps a free-running up-count for a timer subsystem. In its normal mode the count advances once for each tick of a prescaler that divides the bus clock by a power of two picked by a small select input. A sticky overflow flag records each wrap of the count and stays set until software clears it with a one-cycle clear strobe.

A one-bit test control, held in an 8-bit register on a simple write/read port, switches the block into a split mode for production test. In split mode the prescaler is skipped and the count is treated as two equal halves. Each half steps on every enabled clock and no carry passes between them, so a short run exercises every bit. The overflow flag then follows the upper half. Writes to the test register are accepted only while the special-mode input is high. A timer enable input freezes both the count and the prescaler when it is low.

Top module: `ftmr_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `count` to 0, `ovf` to 0 and the test register to 0. `reg_rdata` then reads 0x00.
- R2: In normal mode with `en` high, `count` advances by one every 2^k enabled cycles, where k is `div_sel` and any value above 5 acts as 5. After reset, N enabled cycles give floor(N / 2^k).
- R3: In normal mode the count is one 16-bit value. It carries from the low byte into the high byte. A step from 0xFFFF gives 0x0000 and sets `ovf`.
- R4: When test register bit 1 is 1 (split mode), each enabled cycle adds 1 to bits 15:8 and to bits 7:0 separately, with no carry between them. `div_sel` has no effect in this mode.
- R5: In split mode, `ovf` is set when bits 15:8 step from 0xFF to 0x00.
- R6: `reg_rdata` is readable at any time. Bit 1 holds the split-mode bit and every other bit reads 0, whatever value was written.
- R7: A write (`reg_wr` high) while `smode` is low is ignored. The register and the counting mode stay as they were.
- R8: `ovf` stays set until a cycle with `ovf_clr` high. If a new overflow happens in the same cycle as a clear, `ovf` stays set.
- R9: While `en` is low, `count` and the prescaler state hold their values.
- R10: A write that changes the split-mode bit restarts the prescaler from zero and leaves `count` unchanged. The write cycle still counts in the old mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer enable; low freezes count and prescaler |
| div_sel | input | 3 | Prescaler select: divide by 2^div_sel, capped at 32 |
| smode | input | 1 | Special-mode indicator; allows test register writes |
| reg_wr | input | 1 | Test register write strobe |
| reg_wdata | input | 8 | Test register write data (bit 1 = split mode) |
| reg_rdata | output | 8 | Test register read data |
| ovf_clr | input | 1 | Overflow clear strobe |
| count | output | 16 | Current counter value |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench uses the default parameters: a 16-bit count split into two 8-bit halves, a 3-bit select and a divide cap of 32. With these values the select codes 6 and 7 reach the cap, so the clamp is tested. Split mode drives the count to 0xFFFF in 255 cycles. From there one switch back to normal mode and a single step reach the 16-bit wrap, with no need for 65536 cycles. The divide-by-4 setting leaves the prescaler part-way through a period, so a restart on a mode change, or a missing hold while disabled, shows up as a step in the wrong cycle.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;
  localparam int REG_W   = 8;
  localparam int SPLIT_POS = 1;

  typedef enum logic {
    MODE_CHAIN = 1'b0,
    MODE_SPLIT = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/ftmr_ctlreg.sv
module ftmr_ctlreg
  import ftmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             smode,
  input  logic [REG_W-1:0] wdata,
  output cnt_mode_e        mode,
  output logic             mode_chg,
  output logic [REG_W-1:0] rdata
);
  logic split_q;
  logic wr_ok;

  assign wr_ok    = wr && smode;
  assign mode_chg = wr_ok && (wdata[SPLIT_POS] != split_q);
  assign mode     = cnt_mode_e'(split_q);

  always_ff @(posedge clk) begin
    if (rst)        split_q <= 1'b0;
    else if (wr_ok) split_q <= wdata[SPLIT_POS];
  end

  always_comb begin
    rdata            = '0;
    rdata[SPLIT_POS] = split_q;
  end
endmodule

// File: rtl/ftmr_prescale.sv
module ftmr_prescale #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic             bypass,
  output logic             tick
);
  localparam int PRE_W = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  int               lg;

  always_comb begin
    lg   = (int'(sel) > MAX_LOG) ? MAX_LOG : int'(sel);
    mask = PRE_W'((33'd1 << lg) - 33'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (en)        pre_q <= pre_q + 1'b1;
  end

  assign tick = en && (bypass || ((pre_q & mask) == mask));
endmodule

// File: rtl/ftmr_counter.sv
module ftmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             split,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam int H   = CNT_W / 2;
  localparam int SEG = 2;

  logic [SEG-1:0] inc;
  logic [H-1:0]   seg_q [SEG];

  always_comb begin
    inc[0] = step;
    inc[1] = step && (split || (&seg_q[0]));
  end

  for (genvar g = 0; g < SEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)         seg_q[g] <= '0;
      else if (inc[g]) seg_q[g] <= seg_q[g] + 1'b1;
    end
  end

  assign count = {seg_q[1], seg_q[0]};
  assign wrap  = inc[1] && (&seg_q[1]);
endmodule

// File: rtl/ftmr_ovf.sv
module ftmr_ovf (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top
  import ftmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             smode,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  cnt_mode_e mode;
  logic      mode_chg;
  logic      tick;
  logic      wrap;
  logic      split;

  assign split = (mode == MODE_SPLIT);

  ftmr_ctlreg u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .smode(smode), .wdata(reg_wdata),
    .mode(mode), .mode_chg(mode_chg), .rdata(reg_rdata)
  );

  ftmr_prescale #(.SEL_W(SEL_W), .MAX_LOG(MAX_LOG)) u_pre (
    .clk(clk), .rst(rst), .en(en), .sel(div_sel), .restart(mode_chg),
    .bypass(split), .tick(tick)
  );

  ftmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(tick), .split(split),
    .count(count), .wrap(wrap)
  );

  ftmr_ovf u_ovf (
    .clk(clk), .rst(rst), .set(wrap), .clr(ovf_clr), .flag(ovf)
  );
endmodule

// File: rtl/ftmr_check.sv
module ftmr_check #(
  parameter int CNT_W = 16,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             smode,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_rdata,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf
);
  localparam int H = CNT_W / 2;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == '0) && !ovf && (reg_rdata == '0));

  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> ((&$past(count[CNT_W-1:H])) && $past(en)));

  p_split_step_r4: assert property (@(posedge clk) disable iff (rst)
    (en && reg_rdata[1]) |=>
      (count[CNT_W-1:H] == H'($past(count[CNT_W-1:H]) + 1'b1)) &&
      (count[H-1:0]     == H'($past(count[H-1:0]) + 1'b1)));

  p_other_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~(REG_W'(2))) == '0);

  p_wr_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !smode) |=> $stable(reg_rdata));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));
endmodule

bind ftmr_top ftmr_check #(.CNT_W(CNT_W), .REG_W(8)) u_chk (
  .clk(clk), .rst(rst), .en(en), .smode(smode), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
);

// File: tb/ftmr_top_test.sv
module ftmr_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic        smode = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ftmr_top uut (
    .clk(clk), .rst(rst), .en(en), .div_sel(div_sel), .smode(smode),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovf_clr(ovf_clr), .count(count), .ovf(ovf)
  );

  localparam int NV = 9;
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 0};
  localparam int V_N   [NV] = '{100, 100, 100, 100, 100, 100, 100, 100, 300};
  localparam int V_EXP [NV] = '{100, 50, 25, 12, 6, 3, 3, 3, 300};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    en = 1'b0; reg_wr = 1'b0; ovf_clr = 1'b0; smode = 1'b0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic sm);
    reg_wr = 1'b1; reg_wdata = d; smode = sm;
    step(1);
    reg_wr = 1'b0; smode = 1'b0;
  endtask

  task automatic run(input int n);
    en = 1'b1;
    step(n);
    en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    #1;
    do_reset();
    // R1: reset state
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 ovf", 32'(ovf), 32'h0);
    chk("R1 rdata", 32'(reg_rdata), 32'h0);

    // R2/R3/R9: table of divide settings
    for (int i = 0; i < NV; i++) begin
      do_reset();
      div_sel = 3'(V_SEL[i]);
      run(V_N[i]);
      chk("R2 divided count", 32'(count), 32'(V_EXP[i]));
      step(5);
      chk("R9 hold while disabled", 32'(count), 32'(V_EXP[i]));
    end

    // R9: prescaler holds its phase while disabled
    do_reset();
    div_sel = 3'd2;
    run(3);
    step(5);
    run(1);
    chk("R9 prescaler held", 32'(count), 32'h1);

    // R7: write without special mode ignored
    do_reset();
    wr(8'h02, 1'b0);
    chk("R7 rdata", 32'(reg_rdata), 32'h0);
    div_sel = 3'd0;
    run(1);
    chk("R7 still normal mode", 32'(count), 32'h1);

    // R6/R4/R5/R8: split mode
    do_reset();
    wr(8'hFF, 1'b1);
    chk("R6 rdata only bit 1", 32'(reg_rdata), 32'h2);
    div_sel = 3'd3;
    run(1);
    chk("R4 both halves step", 32'(count), 32'h0101);
    run(254);
    chk("R4 halves at top", 32'(count), 32'hFFFF);
    chk("R5 no early overflow", 32'(ovf), 32'h0);
    en = 1'b1; ovf_clr = 1'b1;
    step(1);
    en = 1'b0; ovf_clr = 1'b0;
    chk("R5 wrap count", 32'(count), 32'h0000);
    chk("R8 set wins over clear", 32'(ovf), 32'h1);
    step(3);
    chk("R8 sticky", 32'(ovf), 32'h1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R8 cleared", 32'(ovf), 32'h0);

    // R10/R3: back to normal at 0xFFFF
    run(255);
    chk("R4 second pass", 32'(count), 32'hFFFF);
    wr(8'h00, 1'b1);
    chk("R10 count kept", 32'(count), 32'hFFFF);
    div_sel = 3'd0;
    run(1);
    chk("R3 16-bit wrap", 32'(count), 32'h0000);
    chk("R3 overflow set", 32'(ovf), 32'h1);

    // R10: mode change restarts prescaler
    do_reset();
    div_sel = 3'd2;
    run(3);
    wr(8'h02, 1'b1);
    wr(8'h00, 1'b1);
    chk("R10 count kept after toggles", 32'(count), 32'h0);
    run(3);
    chk("R10 prescaler restarted", 32'(count), 32'h0);
    run(1);
    chk("R10 first tick after restart", 32'(count), 32'h1);

    done = 1'b1;
    summary();
  end
endmodule